// File: doc/BRIEF.md
# Address Region Decoder and Bus Router

This block sits between a processor's 32-bit load/store port and the set of memories and register banks behind it. Each request carries an address, a direction, an access size of one, two or four bytes and write data. The router aligns the address to the access size and picks a target region from the top address byte. It then works out a region-local offset and raises that region's select for the cycle of the request. Most regions repeat, so the offset is formed with a per-region mask. The video memory window folds its top part back down. One I/O address is redirected to a fixed offset just past the normal register window.

Reads and writes follow different rules. The boot memory is read-only and is readable only below a limit. The cartridge ROM space takes reads only, while the save-memory space takes both. Anything a region does not accept goes to an internal sink, which drops writes and answers reads with zero. Read data from the chosen target is captured into a register and returned with a valid pulse on the clock after the request. Addresses whose top byte belongs to no region also raise a one-cycle flag at that same point.

Top module: `mem_region_router`

## Requirements
- R1: The target index is chosen from aligned address bits [31:24]: 0x00 gives index 0 (boot), 0x02 gives 1 (external work RAM), 0x03 gives 2 (internal work RAM), 0x04 gives 3 (I/O), 0x05 gives 4 (palette), 0x06 gives 5 (video RAM), 0x07 gives 6 (object attributes), 0x08 to 0x0D give 7 (cartridge) and 0x0E to 0x0F give 8 (save). Select bit k of `tgt_sel` is high only in a cycle with `req_valid` and target k chosen. At most one select bit is ever high.
- R2: `req_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word. A halfword access clears address bit 0 before decoding, and a word access clears bits [1:0].
- R3: The external work RAM offset is the address AND 0x3FFFF. The internal work RAM offset is the address AND 0x7FFF.
- R4: The I/O offset is the address AND 0x7FF. If the low 16 address bits equal 0x8000, the offset is 0x800 instead.
- R5: The palette and object-attribute offsets are the address AND 0x3FF.
- R6: The video RAM offset is the address AND 0x1FFFF, reduced by 0x8000 when that value exceeds 0x18000. A value of exactly 0x18000 is not reduced.
- R7: A boot read with an aligned address below 0x4000 selects target 0, and its offset is the address itself. A boot read at 0x4000 or above selects nothing and returns zero. A boot write selects nothing.
- R8: A write to 0x08 to 0x0D selects nothing. A read or write to 0x0E to 0x0F selects target 8, and a read to 0x08 to 0x0D selects target 7. In both cases the offset is the full aligned address.
- R9: The offset of target k appears on `tgt_off[k*32 +: 32]`. For each read request, `rd_valid` is high on the next cycle and `rd_data` holds the value that the selected target drove on `tgt_rdata[k*32 +: 32]` in the request cycle. `rd_data` holds its value when no read is made.
- R10: If the top byte is 0x01 or 0x10 and above, no select goes high, a read returns zero and `unmapped_access` is high for exactly the next cycle.
- R11: During and just after reset, `rd_valid`, `rd_data` and `unmapped_access` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| tgt_sel | output | 9 | One select per target |
| tgt_write | output | 1 | Direction passed to targets |
| tgt_size | output | 2 | Size passed to targets |
| tgt_wdata | output | 32 | Write data passed to targets |
| tgt_off | output | 288 | Region-local offset, 32 bits per target |
| tgt_rdata | input | 288 | Read data, 32 bits per target |
| rd_valid | output | 1 | Read return valid, one cycle after the request |
| rd_data | output | 32 | Registered read data |
| unmapped_access | output | 1 | One-cycle flag for an address outside every region |

## Verification
The bench builds the router with its default masks and limits: a 128 KiB video window folding above 0x18000, a boot limit of 0x4000 and an I/O alias at 0x8000. These values keep every boundary reachable by directed addresses: both sides of the fold, the alias and its neighbours, and the boot limit. Random requests spread the top byte over 0x00 to 0x1F, so every region, the read/write asymmetries and the unmapped sink all appear under mixed sizes and misaligned low bits. The target memories in the bench answer with data made from the region index and the offset they see, so a wrong route or a wrong offset shows up in the returned word.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  localparam int ADDR_W  = 32;
  localparam int NUM_TGT = 9;

  typedef enum logic [3:0] {
    RG_BOOT  = 4'd0,
    RG_XWRAM = 4'd1,
    RG_IWRAM = 4'd2,
    RG_IO    = 4'd3,
    RG_PAL   = 4'd4,
    RG_VRAM  = 4'd5,
    RG_OAM   = 4'd6,
    RG_CART  = 4'd7,
    RG_SAVE  = 4'd8,
    RG_SINK  = 4'd9
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  typedef struct packed {
    region_e             region;
    logic [ADDR_W-1:0]   offset;
    logic                unmapped;
  } route_t;
endpackage

// File: rtl/mrr_align.sv
module mrr_align
  import mrr_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] aligned
);
  always_comb begin
    aligned = addr;
    case (size_e'(size))
      SZ_HALF:          aligned = {addr[ADDR_W-1:1], 1'b0};
      SZ_WORD, SZ_WALT: aligned = {addr[ADDR_W-1:2], 2'b00};
      default:          aligned = addr;
    endcase
  end
endmodule

// File: rtl/mrr_decode.sv
module mrr_decode
  import mrr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] XWRAM_MASK   = 32'h0003_FFFF,
  parameter logic [ADDR_W-1:0] IWRAM_MASK   = 32'h0000_7FFF,
  parameter logic [ADDR_W-1:0] IO_MASK      = 32'h0000_07FF,
  parameter logic [15:0]       IO_ALIAS_LOW = 16'h8000,
  parameter logic [ADDR_W-1:0] IO_ALIAS_OFF = 32'h0000_0800,
  parameter logic [ADDR_W-1:0] SMALL_MASK   = 32'h0000_03FF,
  parameter logic [ADDR_W-1:0] VRAM_MASK    = 32'h0001_FFFF,
  parameter logic [ADDR_W-1:0] VRAM_FOLD_AT = 32'h0001_8000,
  parameter logic [ADDR_W-1:0] VRAM_FOLD_BY = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] BOOT_LIMIT   = 32'h0000_4000
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output route_t            route
);
  localparam int TOP_LSB = ADDR_W - 8;

  logic [7:0]        top;
  logic [ADDR_W-1:0] vram_raw;

  assign top      = addr[ADDR_W-1:TOP_LSB];
  assign vram_raw = addr & VRAM_MASK;

  always_comb begin
    route.region   = RG_SINK;
    route.offset   = '0;
    route.unmapped = 1'b0;
    case (top)
      8'h00: begin
        if (!is_write && (addr < BOOT_LIMIT)) begin
          route.region = RG_BOOT;
          route.offset = addr;
        end
      end
      8'h02: begin
        route.region = RG_XWRAM;
        route.offset = addr & XWRAM_MASK;
      end
      8'h03: begin
        route.region = RG_IWRAM;
        route.offset = addr & IWRAM_MASK;
      end
      8'h04: begin
        route.region = RG_IO;
        route.offset = (addr[15:0] == IO_ALIAS_LOW) ? IO_ALIAS_OFF : (addr & IO_MASK);
      end
      8'h05: begin
        route.region = RG_PAL;
        route.offset = addr & SMALL_MASK;
      end
      8'h06: begin
        route.region = RG_VRAM;
        route.offset = (vram_raw > VRAM_FOLD_AT) ? (vram_raw - VRAM_FOLD_BY) : vram_raw;
      end
      8'h07: begin
        route.region = RG_OAM;
        route.offset = addr & SMALL_MASK;
      end
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: begin
        if (!is_write) begin
          route.region = RG_CART;
          route.offset = addr;
        end
      end
      8'h0E, 8'h0F: begin
        route.region = RG_SAVE;
        route.offset = addr;
      end
      default: route.unmapped = 1'b1;
    endcase
  end
endmodule

// File: rtl/mrr_return.sv
module mrr_return
  import mrr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_req,
  input  logic                  unm_req,
  input  region_e               region,
  input  logic [NUM_TGT*DW-1:0] tgt_rdata,
  output logic                  rd_valid,
  output logic [DW-1:0]         rd_data,
  output logic                  unmapped_access
);
  logic [DW-1:0] pick;
  logic [DW-1:0] data_d, data_q;
  logic          vld_d, vld_q;
  logic          unm_d, unm_q;

  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_TGT; k++) begin
      if (region == region_e'(k)) pick = tgt_rdata[k*DW +: DW];
    end
    data_d = pick;
    vld_d  = rd_req;
    unm_d  = unm_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      unm_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      unm_q <= unm_d;
      if (rd_req) data_q <= data_d;
    end
  end

  assign rd_valid        = vld_q;
  assign rd_data         = data_q;
  assign unmapped_access = unm_q;
endmodule

// File: rtl/mem_region_router.sv
module mem_region_router
  import mrr_pkg::*;
#(
  parameter int                DW           = 32,
  parameter logic [ADDR_W-1:0] XWRAM_MASK   = 32'h0003_FFFF,
  parameter logic [ADDR_W-1:0] IWRAM_MASK   = 32'h0000_7FFF,
  parameter logic [ADDR_W-1:0] IO_MASK      = 32'h0000_07FF,
  parameter logic [15:0]       IO_ALIAS_LOW = 16'h8000,
  parameter logic [ADDR_W-1:0] IO_ALIAS_OFF = 32'h0000_0800,
  parameter logic [ADDR_W-1:0] SMALL_MASK   = 32'h0000_03FF,
  parameter logic [ADDR_W-1:0] VRAM_MASK    = 32'h0001_FFFF,
  parameter logic [ADDR_W-1:0] VRAM_FOLD_AT = 32'h0001_8000,
  parameter logic [ADDR_W-1:0] VRAM_FOLD_BY = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] BOOT_LIMIT   = 32'h0000_4000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [1:0]                req_size,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic [NUM_TGT-1:0]        tgt_sel,
  output logic                      tgt_write,
  output logic [1:0]                tgt_size,
  output logic [DW-1:0]             tgt_wdata,
  output logic [NUM_TGT*ADDR_W-1:0] tgt_off,
  input  logic [NUM_TGT*DW-1:0]     tgt_rdata,
  output logic                      rd_valid,
  output logic [DW-1:0]             rd_data,
  output logic                      unmapped_access
);
  logic [ADDR_W-1:0] aligned;
  route_t            route;

  mrr_align u_align (
    .size    (req_size),
    .addr    (req_addr),
    .aligned (aligned)
  );

  mrr_decode #(
    .XWRAM_MASK   (XWRAM_MASK),
    .IWRAM_MASK   (IWRAM_MASK),
    .IO_MASK      (IO_MASK),
    .IO_ALIAS_LOW (IO_ALIAS_LOW),
    .IO_ALIAS_OFF (IO_ALIAS_OFF),
    .SMALL_MASK   (SMALL_MASK),
    .VRAM_MASK    (VRAM_MASK),
    .VRAM_FOLD_AT (VRAM_FOLD_AT),
    .VRAM_FOLD_BY (VRAM_FOLD_BY),
    .BOOT_LIMIT   (BOOT_LIMIT)
  ) u_decode (
    .is_write (req_write),
    .addr     (aligned),
    .route    (route)
  );

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_tgt
    assign tgt_sel[k] = req_valid && (route.region == region_e'(k));
    assign tgt_off[k*ADDR_W +: ADDR_W] = tgt_sel[k] ? route.offset : '0;
  end

  assign tgt_write = req_write;
  assign tgt_size  = req_size;
  assign tgt_wdata = req_wdata;

  mrr_return #(.DW(DW)) u_return (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_req          (req_valid && !req_write),
    .unm_req         (req_valid && route.unmapped),
    .region          (route.region),
    .tgt_rdata       (tgt_rdata),
    .rd_valid        (rd_valid),
    .rd_data         (rd_data),
    .unmapped_access (unmapped_access)
  );
endmodule

// File: rtl/mrr_chk.sv
module mrr_chk
  import mrr_pkg::*;
#(
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [7:0]         top,
  input logic [NUM_TGT-1:0] tgt_sel,
  input logic [ADDR_W-1:0]  vram_off,
  input logic               rd_valid,
  input logic [DW-1:0]      rd_data,
  input logic               unmapped_access
);
  logic is_unm;
  assign is_unm = (top == 8'h01) || (top >= 8'h10);

  // R1
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tgt_sel));

  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |-> tgt_sel == '0);

  // R10
  unm_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && is_unm |-> tgt_sel == '0);

  // R10
  unm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && is_unm |=> unmapped_access);

  // R10
  unm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && is_unm |=> rd_data == '0);

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rd_valid);

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

  // R7
  boot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && top == 8'h00 |-> tgt_sel == '0);

  // R8
  cart_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && top >= 8'h08 && top <= 8'h0D |-> tgt_sel == '0);

  // R6
  vram_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[5] |-> vram_off <= 32'h0001_8000);
endmodule

bind mem_region_router mrr_chk #(.DW(DW)) i_mrr_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .top             (req_addr[31:24]),
  .tgt_sel         (tgt_sel),
  .vram_off        (tgt_off[5*32 +: 32]),
  .rd_valid        (rd_valid),
  .rd_data         (rd_data),
  .unmapped_access (unmapped_access)
);

// File: tb/test_mem_region_router.sv
module test_mem_region_router;
  localparam int NT = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [1:0]    req_size;
  logic [31:0]   req_addr, req_wdata;
  logic [NT-1:0] tgt_sel;
  logic          tgt_write;
  logic [1:0]    tgt_size;
  logic [31:0]   tgt_wdata;
  logic [NT*32-1:0] tgt_off, tgt_rdata;
  logic          rd_valid, unmapped_access;
  logic [31:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        e_rv, e_un;
  logic [31:0] e_rd;

  always #2 clk = ~clk;

  mem_region_router i_mem_region_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .tgt_sel(tgt_sel), .tgt_write(tgt_write), .tgt_size(tgt_size),
    .tgt_wdata(tgt_wdata), .tgt_off(tgt_off), .tgt_rdata(tgt_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .unmapped_access(unmapped_access)
  );

  // target memories: answer with region index and the offset they were given
  always_comb begin
    for (int k = 0; k < NT; k++)
      tgt_rdata[k*32 +: 32] = {4'hA, 4'(k), tgt_off[k*32 +: 24]};
  end

  task automatic chk(bit ok, string tag, string note, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, note, act, exp);
    end
  endtask

  function automatic string tag_of(int t);
    if (t == 0) return "R7";
    if (t == 2 || t == 3) return "R3";
    if (t == 4) return "R4";
    if (t == 5 || t == 7) return "R5";
    if (t == 6) return "R6";
    if (t >= 8 && t <= 15) return "R8";
    return "R10";
  endfunction

  // behavioural reference
  function automatic void model(bit w, bit [1:0] sz, bit [31:0] a,
                                output int ri, output bit [31:0] off, output bit unm);
    bit [31:0] x;
    int t;
    x = a;
    if (sz == 2'd1) x = x - (x % 2);
    else if (sz >= 2'd2) x = x - (x % 4);
    t = int'(x / 32'h0100_0000);
    ri = -1; off = 0; unm = 0;
    if (t == 0) begin
      if (!w && x < 32'h4000) begin ri = 0; off = x; end
    end else if (t == 2) begin ri = 1; off = x % 32'h40000; end
    else if (t == 3) begin ri = 2; off = x % 32'h8000; end
    else if (t == 4) begin
      ri = 3;
      off = ((x % 32'h10000) == 32'h8000) ? 32'h800 : x % 32'h800;
    end
    else if (t == 5) begin ri = 4; off = x % 32'h400; end
    else if (t == 7) begin ri = 6; off = x % 32'h400; end
    else if (t == 6) begin
      ri = 5; off = x % 32'h20000;
      if (off > 32'h18000) off = off - 32'h8000;
    end
    else if (t >= 8 && t <= 13) begin
      if (!w) begin ri = 7; off = x; end
    end
    else if (t == 14 || t == 15) begin ri = 8; off = x; end
    else unm = 1;
  endfunction

  task automatic step(bit v, bit w, bit [1:0] sz, bit [31:0] a, string note);
    int ri;
    bit [31:0] off;
    bit unm;
    logic [NT-1:0] es;
    string tg;
    @(negedge clk);
    // registered return from the previous request (R9, R10)
    chk(rd_valid === e_rv, "R9", {note, " rd_valid(prev)"}, 32'(rd_valid), 32'(e_rv));
    chk(rd_data === e_rd, "R9", {note, " rd_data(prev)"}, rd_data, e_rd);
    chk(unmapped_access === e_un, "R10", {note, " flag(prev)"}, 32'(unmapped_access), 32'(e_un));
    req_valid = v; req_write = w; req_size = sz; req_addr = a;
    req_wdata = a ^ 32'h5A5A_0F0F;
    #1;
    model(w, sz, a, ri, off, unm);
    tg = tag_of(int'(a[31:24]));
    es = '0;
    if (v && ri >= 0) es[ri] = 1'b1;
    chk(tgt_sel === es, "R1", {note, " sel"}, 32'(tgt_sel), 32'(es));
    if (!v || ri < 0) chk(tgt_sel === '0, tg, {note, " no target"}, 32'(tgt_sel), 32'd0);
    if (v && ri >= 0)
      chk(tgt_off[ri*32 +: 32] === off, tg, {note, " offset"}, tgt_off[ri*32 +: 32], off);
    chk(tgt_wdata === req_wdata && tgt_write === w && tgt_size === sz, "R1",
        {note, " passthrough"}, tgt_wdata, req_wdata);
    e_rv = v && !w;
    if (v && !w) e_rd = (ri >= 0) ? {4'hA, 4'(ri), off[23:0]} : 32'd0;
    e_un = v && unm;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    e_rv = 0; e_rd = 0; e_un = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(rd_valid === 1'b0, "R11", "reset rd_valid", 32'(rd_valid), 32'd0);
    chk(rd_data === 32'd0, "R11", "reset rd_data", rd_data, 32'd0);
    chk(unmapped_access === 1'b0, "R11", "reset flag", 32'(unmapped_access), 32'd0);
    rst_n = 1'b1;

    step(1, 0, 2'd0, 32'h0000_1234, "R7 boot read low");
    step(1, 0, 2'd2, 32'h0000_3FFF, "R7 R2 boot word below limit");
    step(1, 0, 2'd0, 32'h0000_4000, "R7 boot read at limit");
    step(1, 1, 2'd2, 32'h0000_0010, "R7 boot write");
    step(1, 0, 2'd2, 32'h0204_5677, "R3 R2 xwram mirror word");
    step(1, 1, 2'd1, 32'h0300_ABCD, "R3 R2 iwram half write");
    step(1, 0, 2'd0, 32'h0400_8000, "R4 io alias");
    step(1, 0, 2'd1, 32'h0401_8001, "R4 R2 io alias half");
    step(1, 0, 2'd0, 32'h0400_8001, "R4 io alias neighbour");
    step(1, 0, 2'd3, 32'h0412_3FFF, "R4 R2 io mask size3");
    step(1, 0, 2'd0, 32'h0500_0FFF, "R5 palette mirror");
    step(1, 1, 2'd0, 32'h0700_1401, "R5 oam write");
    step(1, 0, 2'd0, 32'h0601_8000, "R6 vram fold edge");
    step(1, 0, 2'd0, 32'h0601_8001, "R6 vram folded");
    step(1, 0, 2'd2, 32'h0603_FFFF, "R6 vram top mirror");
    step(1, 0, 2'd0, 32'h0600_1234, "R6 vram low");
    step(1, 0, 2'd2, 32'h0812_3456, "R8 cart read");
    step(1, 1, 2'd2, 32'h0912_3456, "R8 cart write dropped");
    step(1, 1, 2'd2, 32'h0B00_0000, "R8 cart ws1 write dropped");
    step(1, 1, 2'd0, 32'h0D00_0001, "R8 cart top write dropped");
    step(1, 0, 2'd0, 32'h0D00_0001, "R8 cart top read");
    step(1, 1, 2'd0, 32'h0E00_0123, "R8 save write");
    step(1, 0, 2'd0, 32'h0F00_0456, "R8 save read");
    step(1, 0, 2'd0, 32'h0100_0000, "R10 unmapped read");
    step(1, 1, 2'd2, 32'h1000_0000, "R10 unmapped write");
    step(1, 0, 2'd2, 32'hFFFF_FFFF, "R10 R2 unmapped top");
    step(0, 0, 2'd0, 32'h0200_0000, "R9 idle hold");
    step(0, 1, 2'd0, 32'h0100_0000, "R10 idle unmapped");
    step(1, 0, 2'd0, 32'h0200_0004, "R9 back to back a");
    step(1, 0, 2'd0, 32'h0300_0008, "R9 back to back b");

    for (int i = 0; i < 400; i++) begin
      bit [31:0] a;
      a = $urandom;
      a[31:24] = 8'($urandom_range(0, 31));
      if (($urandom % 5) == 0) a[15:0] = 16'h8000 | 16'($urandom_range(0, 3));
      step(($urandom % 8) != 0, $urandom % 2, 2'($urandom % 4), a, "R1 random");
    end
    step(0, 0, 2'd0, 32'd0, "R9 drain");
    step(0, 0, 2'd0, 32'd0, "R9 drain end");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule